// File: doc/BRIEF.md
# Serial Bus Receive Error Classifier

This block sits behind the symbol decoder of a byte-oriented, J1850-style serial link controller. It receives one decoded symbol event per cycle: start of frame, data bit, end of data, end of frame, break or invalid. It also receives the bit value, the bus level and a few status lines from the local transmitter. From these it sorts link errors into a small set of vector codes.

Received frames are checked with a CRC-8 residue test. Symbol, framing and break conditions are detected while the frame is being received. A fault seen while the local node is transmitting is reported as loss of arbitration first. The block also decides when a pending transmit command may start, and it aborts a start that the bus cannot carry.

Pending conditions are kept as flags. The highest-priority flag is shown on a vector output, together with an interrupt request. A CPU read strobe removes only the code that is currently shown. Analog timing, waveform shaping and the register bus belong to other blocks.

Top module: `bus_err_classifier`

## Requirements
- R1: After a synchronous active-low reset, `vec_code` is 0x00 and `irq`, `tx_permit` and `tx_abort` are all 0.
- R2: Symbol codes on `sym_kind` are: 0 start of frame, 1 data bit, 2 end of data, 3 end of frame, 4 break, 5 invalid. Data bits are fed MSB first into a CRC with polynomial x^8+x^4+x^3+x^2+1, preset to 0xFF at start of frame. At end of data on a byte boundary, a residue other than 0xC4 raises code 0x18.
- R3: An end-of-data or end-of-frame symbol that arrives when the in-frame bit count is not a multiple of eight raises code 0x1C.
- R4: An invalid symbol inside a frame with `tx_active` low raises code 0x1C and nothing else.
- R5: An invalid symbol inside a frame with `tx_active` high raises code 0x14 and code 0x1C together. 0x14 is shown first, and 0x1C is shown after 0x14 has been read.
- R6: A break symbol raises code 0x1C. Afterwards every symbol is ignored until `bus_active` is low for a cycle with no symbol. Only then is a start of frame accepted again.
- R7: `bus_active` high while `tx_eod_slot` is high (the local end of data is being sent) raises code 0x1C.
- R8: A pulse on `tx_req` is held as a pending command. `tx_permit` is high only while a command is pending and `bus_active` is low.
- R9: `tx_sof` with `bus_active` low (start of frame cannot drive the bus) raises code 0x1C, pulses `tx_abort` for one cycle on the next edge and drops the pending command. Any `tx_sof` consumes the command.
- R10: Priority is 0x14 over 0x18 over 0x1C. A `vec_rd` strobe clears only the code being shown. With nothing pending, `vec_code` is 0x00 and `irq` is low. Otherwise `irq` is high.
- R11: After any fault, once it has cleared, correct frames and transmit requests behave normally without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_kind | input | 3 | Symbol code (see R2) |
| rx_bit | input | 1 | Value of a data-bit symbol |
| bus_active | input | 1 | Bus is at its active (dominant) level |
| tx_active | input | 1 | Local transmitter is sending the current frame |
| tx_req | input | 1 | CPU transmit command pulse |
| tx_sof | input | 1 | Transmitter is driving its start of frame this cycle |
| tx_eod_slot | input | 1 | Transmitter is sending its end of data this cycle |
| vec_rd | input | 1 | CPU read strobe of the state vector |
| vec_code | output | 8 | Highest-priority pending code, 0x00 if none |
| irq | output | 1 | Interrupt request, high while any code is pending |
| tx_permit | output | 1 | A pending transmit may start now |
| tx_abort | output | 1 | One-cycle pulse: transmission aborted |

## Verification
A symbol, `tx_sof`, `tx_eod_slot` or `vec_rd` accepted at a rising edge changes `vec_code` and `irq` straight after that edge. `tx_abort` is also updated after that same edge, with no further delay. `tx_permit` follows `bus_active` within the same cycle. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a cycle after the edge that used the stimulus. Random frames are checked against a CRC residue computed in the bench. Stacked codes are popped one read at a time, and each read is checked.

// File: rtl/bec_pkg.sv
// Shared types and code values for the bus error classifier.
// Assumes the symbol decoder uses the 3-bit encoding below.
package bec_pkg;
    typedef enum logic [2:0] {
        SYM_SOF = 3'd0,
        SYM_BIT = 3'd1,
        SYM_EOD = 3'd2,
        SYM_EOF = 3'd3,
        SYM_BRK = 3'd4,
        SYM_INV = 3'd5
    } sym_e;

    typedef enum logic [1:0] {
        RX_HUNT  = 2'd0,   // waiting for start of frame
        RX_FRAME = 2'd1,   // inside a frame
        RX_QUIET = 2'd2    // waiting for a passive bus
    } rx_state_e;

    localparam int         CODE_W    = 8;
    localparam logic [7:0] CODE_LOA  = 8'h14;
    localparam logic [7:0] CODE_CRC  = 8'h18;
    localparam logic [7:0] CODE_SYM  = 8'h1C;
    localparam logic [7:0] CRC_GOOD  = 8'hC4;
endpackage

// File: rtl/bec_crc.sv
// Serial CRC register, MSB first. init presets it; shift folds in one bit.
// Assumes init and shift are never high together.
module bec_crc #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   POLY = 8'h1D,
    parameter logic [W-1:0]   SEED = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic fb;
    assign fb = crc[W-1] ^ din;

    // Preset, shift, or hold the residue.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc <= SEED;
        else if (init)  crc <= SEED;
        else if (shift) crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/bec_vector.sv
// Pending-flag stack with fixed priority: index 0 wins. A read clears
// only the flag on show; a raise in the same cycle wins over the clear.
module bec_vector #(
    parameter int                     NSRC   = 3,
    parameter int                     W      = 8,
    parameter logic [NSRC*W-1:0]      CODES  = {8'h1C, 8'h18, 8'h14}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raise,
    input  logic            rd,
    output logic [W-1:0]    code,
    output logic            irq
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] show;

    // Pick the highest-priority pending flag and its code.
    always_comb begin
        show = '0;
        code = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                show = '0;
                show[i] = 1'b1;
                code = CODES[i*W +: W];
            end
        end
    end

    assign irq = |pend;

    // Set on raise, clear the shown flag on read.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= raise | (pend & ~(show & {NSRC{rd}}));
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> code == '0);                                              // R10
    AST_TOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] |-> code == CODES[W-1:0]);                                 // R5

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && show[g] && !raise[g]) |=> !pend[g]);                    // R10
        AST_KEEP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[g] && !show[g]) |=> pend[g]);                            // R10
    end
endmodule

// File: rtl/bus_err_classifier.sv
// Receive error classifier for a byte-oriented serial link. Tracks frame
// state from decoded symbols, checks the CRC residue, raises vector codes,
// and gates transmit starts on the bus level. Assumes at most one symbol
// per cycle and a power-of-two byte width.
module bus_err_classifier #(
    parameter int BYTE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic [2:0] sym_kind,
    input  logic       rx_bit,
    input  logic       bus_active,
    input  logic       tx_active,
    input  logic       tx_req,
    input  logic       tx_sof,
    input  logic       tx_eod_slot,
    input  logic       vec_rd,
    output logic [7:0] vec_code,
    output logic       irq,
    output logic       tx_permit,
    output logic       tx_abort
);
    import bec_pkg::*;

    localparam int POS_W = $clog2(BYTE_W);

    rx_state_e        st, st_nx;
    sym_e             kind;
    logic [POS_W-1:0] pos;
    logic [7:0]       crc;
    logic             crc_init, crc_shift;
    logic             r_loa, r_crc, r_sym;
    logic             tx_pend;
    logic             stuck_low;

    assign kind      = sym_e'(sym_kind);
    assign stuck_low = tx_sof && !bus_active;

    bec_crc #(.W(8), .POLY(8'h1D), .SEED(8'hFF)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .shift(crc_shift),
        .din(rx_bit), .crc(crc)
    );

    // Frame tracking and error raising from the current symbol.
    always_comb begin
        st_nx     = st;
        crc_init  = 1'b0;
        crc_shift = 1'b0;
        r_loa     = 1'b0;
        r_crc     = 1'b0;
        r_sym     = (tx_eod_slot && bus_active) || stuck_low;
        if (sym_valid && kind == SYM_BRK) begin
            r_sym = 1'b1;
            st_nx = RX_QUIET;
        end else begin
            case (st)
                RX_HUNT: if (sym_valid && kind == SYM_SOF) begin
                    crc_init = 1'b1;
                    st_nx    = RX_FRAME;
                end
                RX_FRAME: if (sym_valid) begin
                    case (kind)
                        SYM_BIT: crc_shift = 1'b1;
                        SYM_EOD, SYM_EOF: begin
                            if (pos != '0) begin
                                r_sym = 1'b1;
                                st_nx = RX_QUIET;
                            end else begin
                                r_crc = (kind == SYM_EOD) && (crc != CRC_GOOD);
                                st_nx = RX_HUNT;
                            end
                        end
                        default: begin
                            r_sym = 1'b1;
                            r_loa = tx_active;
                            st_nx = RX_QUIET;
                        end
                    endcase
                end
                default: if (!bus_active && !sym_valid) st_nx = RX_HUNT;
            endcase
        end
    end

    // State and bit position within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RX_HUNT;
            pos <= '0;
        end else begin
            st <= st_nx;
            if (crc_init)       pos <= '0;
            else if (crc_shift) pos <= pos + 1'b1;
        end
    end

    // Transmit command hold and abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_pend  <= 1'b0;
            tx_abort <= 1'b0;
        end else begin
            tx_pend  <= (tx_pend || tx_req) && !tx_sof;
            tx_abort <= stuck_low;
        end
    end

    assign tx_permit = tx_pend && !bus_active;

    bec_vector #(.NSRC(3), .W(CODE_W), .CODES({CODE_SYM, CODE_CRC, CODE_LOA})) u_vec (
        .clk(clk), .rst_n(rst_n), .raise({r_sym, r_crc, r_loa}),
        .rd(vec_rd), .code(vec_code), .irq(irq)
    );

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_QUIET && bus_active) |=> st != RX_FRAME);                // R6
    AST_CRC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_FRAME && sym_valid && kind == SYM_EOD && pos == '0 && crc != CRC_GOOD)
        |=> irq);                                                          // R2
    AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (irq && !tx_permit));                                 // R9
    AST_LOA_WITH_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        r_loa |-> r_sym);                                                  // R5
endmodule

// File: tb/sim_bus_err_classifier.sv
module sim_bus_err_classifier;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_valid = 0, rx_bit = 0, bus_active = 0, tx_active = 0;
    logic tx_req = 0, tx_sof = 0, tx_eod_slot = 0, vec_rd = 0;
    logic [2:0] sym_kind = 0;
    logic [7:0] vec_code;
    logic irq, tx_permit, tx_abort;
    int checks = 0, fails = 0;
    logic [7:0] fr [0:7];

    always #2 clk = ~clk;

    bus_err_classifier u0 (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[7] ^ b[i];
            c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
        end
        return c;
    endfunction

    function automatic logic [7:0] residue(input int n);
        logic [7:0] c;
        c = 8'hFF;
        for (int i = 0; i < n; i++) c = crc_byte(c, fr[i]);
        return c;
    endfunction

    task automatic sym(input logic [2:0] k, input logic b);
        @(negedge clk); sym_valid = 1; sym_kind = k; rx_bit = b;
        @(negedge clk); sym_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd;
        @(negedge clk); vec_rd = 1;
        @(negedge clk); vec_rd = 0;
    endtask

    task automatic bits(input int n);
        for (int i = 0; i < n; i++) sym(3'd1, i[0]);
    endtask

    task automatic frame(input int n);
        sym(3'd0, 0);
        for (int i = 0; i < n; i++)
            for (int j = 7; j >= 0; j--) sym(3'd1, fr[i][j]);
        sym(3'd2, 0);
        sym(3'd3, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        idle(3);
        chk("R1 vec", vec_code, 8'h00);
        chk("R1 flags", {5'd0, irq, tx_permit, tx_abort}, 8'h00);
        @(negedge clk); rst_n = 1;
        idle(1);

        // R2 random frames, some corrupted
        for (int f = 0; f < 30; f++) begin
            int n;
            logic [7:0] exp;
            n = 1 + ($urandom % 5);
            for (int i = 0; i < n; i++) fr[i] = 8'($urandom);
            fr[n] = ~residue(n);
            if ($urandom % 2) fr[$urandom % (n + 1)] ^= 8'(1 << ($urandom % 8));
            exp = (residue(n + 1) != 8'hC4) ? 8'h18 : 8'h00;
            frame(n + 1);
            chk("R2 crc vec", vec_code, exp);
            chk("R10 irq", {7'd0, irq}, {7'd0, exp != 0});
            if (exp != 0) begin rd; chk("R10 cleared", vec_code, 8'h00); end
        end

        // R3 framing on end of data and on end of frame
        sym(3'd0, 0); bits(5); sym(3'd2, 0);
        chk("R3 eod framing", vec_code, 8'h1C);
        rd; idle(2);
        sym(3'd0, 0); bits(12); sym(3'd3, 0);
        chk("R3 eof framing", vec_code, 8'h1C);
        rd; idle(2);

        // R4 invalid symbol while receiving only
        sym(3'd0, 0); bits(4); sym(3'd5, 0);
        chk("R4 inv rx", vec_code, 8'h1C);
        rd; chk("R4 single code", {7'd0, irq}, 8'h00); idle(2);

        // R5 invalid while transmitting: stacked codes
        tx_active = 1;
        sym(3'd0, 0); bits(3); sym(3'd5, 0);
        tx_active = 0;
        chk("R5 loa first", vec_code, 8'h14);
        rd; chk("R5 sym next", vec_code, 8'h1C);
        rd; chk("R10 empty", vec_code, 8'h00); idle(2);

        // R10 priority: crc over symbol error
        for (int i = 0; i < 2; i++) fr[i] = 8'h00;
        frame(2);
        sym(3'd0, 0); bits(3); sym(3'd2, 0);
        chk("R10 crc over sym", vec_code, 8'h18);
        rd; chk("R10 sym after", vec_code, 8'h1C);
        rd; chk("R10 irq low", {7'd0, irq}, 8'h00); idle(2);

        // R6 break, then symbols ignored while bus active
        sym(3'd0, 0); bits(3);
        bus_active = 1;
        sym(3'd4, 0);
        chk("R6 break", vec_code, 8'h1C);
        rd;
        frame(2);
        chk("R6 ignored while active", vec_code, 8'h00);
        bus_active = 0; idle(2);
        frame(2);
        chk("R6 resumes after idle", vec_code, 8'h18);
        rd; idle(1);

        // R7 active bus during own end of data
        @(negedge clk); tx_eod_slot = 1; bus_active = 1;
        @(negedge clk); tx_eod_slot = 0; bus_active = 0;
        chk("R7 eod collision", vec_code, 8'h1C);
        rd;

        // R8 permission waits for passive bus
        @(negedge clk); bus_active = 1; tx_req = 1;
        @(negedge clk); tx_req = 0;
        chk("R8 held while active", {7'd0, tx_permit}, 8'h00);
        bus_active = 0; #1;
        chk("R8 permit when passive", {7'd0, tx_permit}, 8'h01);

        // R9 start cannot drive bus
        @(negedge clk); tx_sof = 1;
        @(negedge clk); tx_sof = 0;
        chk("R9 abort pulse", {7'd0, tx_abort}, 8'h01);
        chk("R9 code", vec_code, 8'h1C);
        chk("R9 command dropped", {7'd0, tx_permit}, 8'h00);
        idle(1);
        chk("R9 abort one cycle", {7'd0, tx_abort}, 8'h00);
        rd;

        // R11 recovery: good start and good frame
        @(negedge clk); tx_req = 1;
        @(negedge clk); tx_req = 0;
        chk("R11 permit again", {7'd0, tx_permit}, 8'h01);
        @(negedge clk); tx_sof = 1; bus_active = 1;
        @(negedge clk); tx_sof = 0;
        chk("R11 no abort", {7'd0, tx_abort, irq}, 8'h00);
        bus_active = 0; idle(1);
        chk("R9 consumed by start", {7'd0, tx_permit}, 8'h00);
        fr[0] = 8'hA5; fr[1] = ~residue(1);
        frame(2);
        chk("R11 good frame", vec_code, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule